// File: doc/BRIEF.md
# Timer Channel Event Status Register

This block holds the 32-bit status word of one timer/capture channel. Three bits are sticky: an event flag, an overrun indicator and a counter-overflow indicator. Two bits show live pin levels. The capture/compare logic and the channel counter report events to the block as single-cycle strobes. Software reads the word and clears the sticky bits with a write-one-to-clear through a simple single-cycle bus port. The register decodes at one word offset of the channel window, 0x10 by default.

The event flag drives a level request output toward the interrupt controller and the DMA controller. While DMA servicing is enabled, the DMA controller can clear the flag with a strobe. A flag event that arrives while the flag is still set records an overrun. Clearing the flag from software also clears that overrun.

Top module: `tmr_evt_status`

## Requirements
- R1: After reset, the flag (bit 0), the overrun bit (bit 31) and the overflow bit (bit 15) are all 0, and `flagReq` is 0.
- R2: A capture strobe or a match strobe sets the flag. The new value is visible on the cycle after the strobe.
- R3: A capture or match strobe that arrives while the flag is already 1 sets the overrun bit (bit 31).
- R4: A write to the register offset with bit 0 = 1 clears both the flag and the overrun bit. A write with bit 31 = 1 and bit 0 = 0 clears only the overrun bit.
- R5: A counter overflow strobe sets bit 15. Only a write to the register offset with bit 15 = 1 clears it; writing 1 to bit 0 or bit 31 leaves it set.
- R6: Writing 0 to a bit leaves it unchanged. A write to any other offset changes nothing.
- R7: `dmaClr` clears the flag only while `dmaEn` is 1; with `dmaEn` at 0 it is ignored. The DMA clear leaves the overrun bit unchanged.
- R8: `flagReq` always equals the flag bit.
- R9: A read at the register offset returns `pinIn` at bit 2 and `pinOut` at bit 1. All other bits outside 0, 15 and 31 read as 0. A read at any other offset returns 0.
- R10: A set strobe in the same cycle as a clear (software or DMA) of the same bit leaves the bit at 1. The overrun bit is set only if the flag was already 1 before that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W (8) | Byte offset within the channel window |
| busWe | input | 1 | Write enable, one cycle per write |
| busWdata | input | 32 | Write data, 1 = clear the bit |
| busRdata | output | 32 | Read data, combinational from `busAddr` |
| captureEvt | input | 1 | Input-capture event strobe |
| matchEvt | input | 1 | Comparator match event strobe |
| cntOverflow | input | 1 | Channel counter overflow strobe |
| dmaEn | input | 1 | DMA servicing enabled for the flag |
| dmaClr | input | 1 | DMA controller clear strobe for the flag |
| pinIn | input | 1 | Filtered, synchronized input pin level |
| pinOut | input | 1 | Current output pin level |
| flagReq | output | 1 | Interrupt/DMA request level, equal to the flag |

## Verification
The assertions check on every cycle that:
- event strobes set the flag, and set the overrun bit when the flag was already high;
- the overrun bit never rises while the flag was low;
- the flag and overflow bits hold unless a qualifying clear arrives;
- the pin bits and unused bits of a read at the register offset are correct.

Only the bench's scenarios can show the full sequences:
- set then clear;
- a double event leaving an overrun, then clearing it through either bit;
- an overflow that survives writes to its neighbours and to another offset;
- a DMA clear that is dropped while DMA is disabled;
- the outcome when a set and a clear land in the same cycle.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int DATA_W      = 32;
  localparam int BIT_OVR     = 31;
  localparam int BIT_OVF     = 15;
  localparam int BIT_PIN_IN  = 2;
  localparam int BIT_PIN_OUT = 1;
  localparam int BIT_FLAG    = 0;
  localparam int N_STICKY    = 3;
  localparam int IDX_FLAG    = 0;
  localparam int IDX_OVR     = 1;
  localparam int IDX_OVF     = 2;

  typedef struct packed {
    logic setFlag;
    logic clrFlag;
    logic setOvr;
    logic clrOvr;
    logic setOvf;
    logic clrOvf;
  } stsStrobe_t;
endpackage

// File: rtl/tmr_evt_ctrl.sv
module tmr_evt_ctrl
  import tmr_evt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h10
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              captureEvt,
  input  logic              matchEvt,
  input  logic              cntOverflow,
  input  logic              dmaEn,
  input  logic              dmaClr,
  input  logic              flagQ,
  output logic              regHit,
  output stsStrobe_t        strb
);
  logic wrHit;
  logic flagEvt;
  logic swClrFlag;

  assign regHit    = (busAddr == REG_OFFSET);
  assign wrHit     = regHit & busWe;
  assign flagEvt   = captureEvt | matchEvt;
  assign swClrFlag = wrHit & busWdata[BIT_FLAG];

  always_comb begin
    strb         = '0;
    strb.setFlag = flagEvt;
    strb.clrFlag = swClrFlag | (dmaEn & dmaClr);
    strb.setOvr  = flagEvt & flagQ;
    strb.clrOvr  = swClrFlag | (wrHit & busWdata[BIT_OVR]);
    strb.setOvf  = cntOverflow;
    strb.clrOvf  = wrHit & busWdata[BIT_OVF];
  end
endmodule

// File: rtl/tmr_evt_dp.sv
module tmr_evt_dp
  import tmr_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  stsStrobe_t        strb,
  input  logic              regHit,
  input  logic              pinIn,
  input  logic              pinOut,
  output logic              flagQ,
  output logic              ovrQ,
  output logic              ovfQ,
  output logic [DATA_W-1:0] rdWord
);
  logic [N_STICKY-1:0] setVec;
  logic [N_STICKY-1:0] clrVec;
  logic [N_STICKY-1:0] bitQ;

  assign setVec[IDX_FLAG] = strb.setFlag;
  assign clrVec[IDX_FLAG] = strb.clrFlag;
  assign setVec[IDX_OVR]  = strb.setOvr;
  assign clrVec[IDX_OVR]  = strb.clrOvr;
  assign setVec[IDX_OVF]  = strb.setOvf;
  assign clrVec[IDX_OVF]  = strb.clrOvf;

  for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          bitQ[i] <= 1'b0;
      else if (setVec[i]) bitQ[i] <= 1'b1;
      else if (clrVec[i]) bitQ[i] <= 1'b0;
    end
  end

  assign flagQ = bitQ[IDX_FLAG];
  assign ovrQ  = bitQ[IDX_OVR];
  assign ovfQ  = bitQ[IDX_OVF];

  always_comb begin
    rdWord = '0;
    if (regHit) begin
      rdWord[BIT_OVR]     = ovrQ;
      rdWord[BIT_OVF]     = ovfQ;
      rdWord[BIT_PIN_IN]  = pinIn;
      rdWord[BIT_PIN_OUT] = pinOut;
      rdWord[BIT_FLAG]    = flagQ;
    end
  end
endmodule

// File: rtl/tmr_evt_status.sv
module tmr_evt_status
  import tmr_evt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              captureEvt,
  input  logic              matchEvt,
  input  logic              cntOverflow,
  input  logic              dmaEn,
  input  logic              dmaClr,
  input  logic              pinIn,
  input  logic              pinOut,
  output logic              flagReq
);
  stsStrobe_t strb;
  logic       regHit;
  logic       flagQ;
  logic       ovrQ;
  logic       ovfQ;

  tmr_evt_ctrl #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) ctrl_i (
    .busAddr    (busAddr),
    .busWe      (busWe),
    .busWdata   (busWdata),
    .captureEvt (captureEvt),
    .matchEvt   (matchEvt),
    .cntOverflow(cntOverflow),
    .dmaEn      (dmaEn),
    .dmaClr     (dmaClr),
    .flagQ      (flagQ),
    .regHit     (regHit),
    .strb       (strb)
  );

  tmr_evt_dp dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .regHit(regHit),
    .pinIn (pinIn),
    .pinOut(pinOut),
    .flagQ (flagQ),
    .ovrQ  (ovrQ),
    .ovfQ  (ovfQ),
    .rdWord(busRdata)
  );

  assign flagReq = flagQ;
endmodule

// File: rtl/tmr_evt_chk.sv
module tmr_evt_chk
  import tmr_evt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h10
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              captureEvt,
  input logic              matchEvt,
  input logic              cntOverflow,
  input logic              dmaEn,
  input logic              dmaClr,
  input logic              pinIn,
  input logic              pinOut,
  input logic              flagReq,
  input logic              flagQ,
  input logic              ovrQ,
  input logic              ovfQ
);
  localparam logic [DATA_W-1:0] USED_MASK =
    (DATA_W'(1) << BIT_OVR) | (DATA_W'(1) << BIT_OVF) | (DATA_W'(1) << BIT_PIN_IN) |
    (DATA_W'(1) << BIT_PIN_OUT) | (DATA_W'(1) << BIT_FLAG);

  logic hit, evt, swFlagClr;
  assign hit       = (busAddr == REG_OFFSET);
  assign evt       = captureEvt | matchEvt;
  assign swFlagClr = hit & busWe & busWdata[BIT_FLAG];

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!flagQ && !ovrQ && !ovfQ && !flagReq)); // R1
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    evt |=> flagQ); // R2
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rstN)
    (evt && flagQ) |=> ovrQ); // R3
  AST_FLAG_SW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (swFlagClr && !evt) |=> (!flagQ && !ovrQ)); // R4
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rstN)
    cntOverflow |=> ovfQ); // R5
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ovfQ && !(hit && busWe && busWdata[BIT_OVF])) |=> ovfQ); // R5
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !swFlagClr && !(dmaEn && dmaClr)) |=> flagQ); // R7
  AST_FLAG_REQ_READ: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (busRdata[BIT_FLAG] == flagReq)); // R8
  AST_PIN_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (busRdata[BIT_PIN_IN] == pinIn && busRdata[BIT_PIN_OUT] == pinOut)); // R9
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRdata & ~USED_MASK) == '0); // R9
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (busRdata == '0)); // R9
  AST_OVR_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (!ovrQ && !flagQ) |=> !ovrQ); // R10
endmodule

bind tmr_evt_status tmr_evt_chk #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) chk_i (.*);

// File: tb/tmr_evt_status_tb_top.sv
module tmr_evt_status_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [7:0] OFF = 8'h10;
  localparam logic [7:0] OTHER = 8'h14;

  typedef struct {
    logic [31:0] expData;
    logic        expFlag;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic captureEvt = 1'b0, matchEvt = 1'b0, cntOverflow = 1'b0;
  logic dmaEn = 1'b0, dmaClr = 1'b0;
  logic pinIn = 1'b0, pinOut = 1'b0;
  logic flagReq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  item_t sbQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_evt_status dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .captureEvt(captureEvt), .matchEvt(matchEvt),
    .cntOverflow(cntOverflow), .dmaEn(dmaEn), .dmaClr(dmaClr),
    .pinIn(pinIn), .pinOut(pinOut), .flagReq(flagReq)
  );

  // monitor: compares a quarter period after each falling edge
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    while (sbQ.size() > 0) begin
      item_t it;
      it = sbQ.pop_front();
      total++;
      if (busRdata !== it.expData || flagReq !== it.expFlag) begin
        bad++;
        $display("FAIL %s: rdata=%h flagReq=%b expected rdata=%h flagReq=%b",
                 it.tag, busRdata, flagReq, it.expData, it.expFlag);
      end
    end
  end

  task automatic drive(input logic cap, input logic mat, input logic ovf,
                       input logic dEn, input logic dClr,
                       input logic we, input logic [7:0] addr, input logic [31:0] wd);
    @(negedge clk);
    captureEvt = cap; matchEvt = mat; cntOverflow = ovf;
    dmaEn = dEn; dmaClr = dClr;
    busWe = we; busAddr = addr; busWdata = wd;
  endtask

  task automatic wr(input logic [31:0] wd);
    drive(0, 0, 0, 0, 0, 1, OFF, wd);
  endtask

  task automatic expectRd(input logic [7:0] addr, input logic [31:0] expData,
                          input logic expFlag, input string tag);
    item_t it;
    drive(0, 0, 0, 0, 0, 0, addr, '0);
    it.expData = expData; it.expFlag = expFlag; it.tag = tag;
    sbQ.push_back(it);
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: cycles=%0d expected=<%0d", cyc, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    expectRd(OFF, 32'h0, 1'b0, "R1 in reset");
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expectRd(OFF, 32'h0, 1'b0, "R1 after reset");

    drive(1, 0, 0, 0, 0, 0, OFF, '0);
    expectRd(OFF, 32'h1, 1'b1, "R2 capture sets flag");
    wr(32'h1);
    expectRd(OFF, 32'h0, 1'b0, "R4 flag write-one clear");

    drive(0, 1, 0, 0, 0, 0, OFF, '0);
    expectRd(OFF, 32'h1, 1'b1, "R2 match sets flag");
    drive(0, 1, 0, 0, 0, 0, OFF, '0);
    expectRd(OFF, 32'h8000_0001, 1'b1, "R3 second event overrun");
    wr(32'h1);
    expectRd(OFF, 32'h0, 1'b0, "R4 flag write clears overrun too");

    drive(1, 0, 0, 0, 0, 0, OFF, '0);
    drive(1, 0, 0, 0, 0, 0, OFF, '0);
    expectRd(OFF, 32'h8000_0001, 1'b1, "R3 capture twice");
    wr(32'h8000_0000);
    expectRd(OFF, 32'h1, 1'b1, "R4 overrun-only clear");
    wr(32'h1);
    expectRd(OFF, 32'h0, 1'b0, "R4 flag clear");

    drive(0, 0, 1, 0, 0, 0, OFF, '0);
    expectRd(OFF, 32'h8000, 1'b0, "R5 overflow sets");
    wr(32'h8000_0001);
    expectRd(OFF, 32'h8000, 1'b0, "R5 neighbour writes keep overflow");
    wr(32'h0);
    expectRd(OFF, 32'h8000, 1'b0, "R6 zero write no effect");
    drive(0, 0, 0, 0, 0, 1, OTHER, 32'hFFFF_FFFF);
    expectRd(OFF, 32'h8000, 1'b0, "R6 other offset write no effect");
    wr(32'h8000);
    expectRd(OFF, 32'h0, 1'b0, "R5 own-bit clear");

    drive(1, 0, 0, 0, 0, 0, OFF, '0);
    drive(0, 0, 0, 0, 1, 0, OFF, '0);
    expectRd(OFF, 32'h1, 1'b1, "R7 dma clear ignored when disabled");
    drive(0, 0, 0, 1, 1, 0, OFF, '0);
    expectRd(OFF, 32'h0, 1'b0, "R7 dma clear when enabled");
    drive(1, 0, 0, 0, 0, 0, OFF, '0);
    drive(1, 0, 0, 0, 0, 0, OFF, '0);
    drive(0, 0, 0, 1, 1, 0, OFF, '0);
    expectRd(OFF, 32'h8000_0000, 1'b0, "R7 dma clear keeps overrun R8");
    wr(32'h8000_0000);
    expectRd(OFF, 32'h0, 1'b0, "R4 overrun clear");

    drive(1, 0, 0, 0, 0, 0, OFF, '0);
    drive(1, 0, 0, 0, 0, 1, OFF, 32'h1);
    expectRd(OFF, 32'h8000_0001, 1'b1, "R10 set beats write clear");
    wr(32'h8000_0001);
    expectRd(OFF, 32'h0, 1'b0, "R4 clear both");
    drive(0, 1, 0, 0, 0, 1, OFF, 32'h1);
    expectRd(OFF, 32'h1, 1'b1, "R10 no overrun from clear flag");
    drive(1, 0, 0, 1, 1, 0, OFF, '0);
    expectRd(OFF, 32'h8000_0001, 1'b1, "R10 set beats dma clear");
    drive(0, 0, 1, 0, 0, 1, OFF, 32'h8000);
    expectRd(OFF, 32'h8000_8001, 1'b1, "R10 overflow set beats clear");
    wr(32'h8000_8001);
    expectRd(OFF, 32'h0, 1'b0, "R4 R5 clear all");

    @(negedge clk); pinIn = 1'b1; pinOut = 1'b0;
    expectRd(OFF, 32'h4, 1'b0, "R9 input pin level");
    @(negedge clk); pinIn = 1'b0; pinOut = 1'b1;
    expectRd(OFF, 32'h2, 1'b0, "R9 output pin level");
    drive(1, 0, 0, 0, 0, 0, OFF, '0);
    expectRd(OTHER, 32'h0, 1'b1, "R9 other offset reads zero R8");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule